// File: doc/BRIEF.md
# Mode-3 Serial Command Front End with Paced Write Buffer

This block is the serial-bus slave front end of an audio playback device. A host selects it with an active-low select line and clocks bytes in mode 3: the clock idles high and every bit is taken on the rising edge. The first byte of each selection is an opcode. The block latches that opcode for the command logic behind it. While the opcode bits arrive, an 8-bit status snapshot goes out on the serial output.

For write opcodes, the bytes that follow go into a 32-entry byte buffer, and a downstream consumer empties it over a valid/ready stream. For the read opcode, each following byte is taken from a read-data port at the previous byte boundary and shifted out.

A ready line paces the host. It drops when the buffer is full, or when a read has no data waiting. A host that keeps clocking while the line is low loses the ready flag in the status byte. On writes, a byte that meets a full buffer is dropped and a sticky interrupt request is raised on an open-drain style output. On reads, the interrupt marks the byte as invalid. The bus pins pass through two-flop synchronizers, so the system clock must run at least eight times the serial clock.

Top module: `spi_flow_slave`

## Requirements
- R1: Serial input bits are taken on synchronized rising edges of `sclk_i`, most significant bit first, and write data bytes reach `rx_data_o` unchanged and in arrival order.
- R2: The first byte after `csn_i` falls is latched on `cmd_o` and held until the next opcode completes, with a single-cycle `cmd_valid_o` pulse.
- R3: During the opcode byte, the block shifts out a status byte, one bit after each falling edge of `sclk_i`, most significant bit first. Bit 7 is `pd_i`, bit 6 is the ready flag, bit 5 is interrupt pending, bit 4 is buffer full, bit 3 is 0, bit 2 is `voice_busy_i`, bit 1 is buffer non-empty and bit 0 is `cmd_busy_i`.
- R4: `miso_oe_o` is the inverse of `csn_i` delayed by two clock edges, so the output is released whenever the synchronized select is high.
- R5: The write buffer holds up to DEPTH (32) bytes in first-in first-out order, and a byte boundary and a consumer pop in the same clock cycle both take effect.
- R6: Outside a read, `rdy_o` is low exactly while the buffer is full, whether the select line is high or low, and rises in the cycle after a pop.
- R7: A write byte that completes while the buffer is full is discarded, and `irq_drive_o` goes high and stays high.
- R8: A falling edge of `sclk_i` while selected with `rdy_o` low clears the status ready flag, which returns to 1 only at a select falling edge seen with `rdy_o` high.
- R9: Opcode 0x04 clears the interrupt request as soon as it completes.
- R10: After opcode 0xA2, each byte boundary takes one byte from the read port when `rd_valid_i` is high, and that byte is shifted out in the next byte. Otherwise `rdy_o` stays low until `rd_valid_i` rises and the byte is taken.
- R11: A falling edge of `sclk_i` while a read waits for data raises `irq_drive_o`.
- R12: After reset `rdy_o` is 1, `irq_drive_o` is 0, `miso_oe_o` is 0, and `rx_valid_o` and `cmd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, idle high |
| csn_i | input | 1 | Active-low select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Drive enable for the serial output pad |
| rdy_o | output | 1 | High when the next byte may be clocked |
| irq_drive_o | output | 1 | 1 = pull the open-drain interrupt pin low |
| pd_i | input | 1 | Power-down flag for the status byte |
| voice_busy_i | input | 1 | Playback-busy flag for the status byte |
| cmd_busy_i | input | 1 | Command-busy flag for the status byte |
| cmd_o | output | 8 | Last latched opcode |
| cmd_valid_o | output | 1 | One-cycle pulse when an opcode completes |
| rx_data_o | output | 8 | Head of the write buffer |
| rx_valid_o | output | 1 | Write buffer not empty |
| rx_ready_i | input | 1 | Consumer pops the head this cycle |
| rd_data_i | input | 8 | Byte offered for a read |
| rd_valid_i | input | 1 | Read byte is available |
| rd_ready_o | output | 1 | Read byte taken this cycle |

## Verification
Two events can land on the same clock edge: a host byte finishing into the buffer and the consumer popping the head. The bench creates this overlap by raising `rx_ready_i` for exactly the cycle in which the synchronized last rising edge commits the byte. It then checks that the popped value was the old head and that the later drain returns the remaining bytes, including the new one, with none lost or repeated. The reference model is a byte queue with an interrupt flag. On every clock the bench compares the output enable against a two-edge delayed copy of the select line.

// File: rtl/spi_flow_pkg.sv
package spi_flow_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    // Status byte, most significant field first
    typedef struct packed {
        logic pwr_down;
        logic ready;
        logic irq_pend;
        logic buf_full;
        logic rsvd;
        logic voice_busy;
        logic buf_avail;
        logic cmd_busy;
    } status_t;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic [BYTE_W-1:0] cmd;
        logic              cmd_vld;
        logic              rdy_flag;
        logic              irq;
        logic              rd_wait;
        logic [BYTE_W-1:0] rd_hold;
    } front_st_t;

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int             W    = 3,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
            prev_q <= INIT;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic [DW-1:0] data_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push_i) ptr_d.wr = step(ptr_q.wr);
        if (pop_i)  ptr_d.rd = step(ptr_q.rd);
        case ({push_i, pop_i})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[ptr_q.wr] <= data_i;
    end

    assign data_o  = mem_q[ptr_q.rd];
    assign empty_o = (ptr_q.cnt == '0);
    assign full_o  = (ptr_q.cnt == CW'(DEPTH));

    // R7: the front end never writes into a full buffer
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i);

    // R5: the consumer never pops an empty buffer
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !pop_i);

endmodule

// File: rtl/spi_flow_slave.sv
module spi_flow_slave
    import spi_flow_pkg::*;
#(
    parameter int                DEPTH   = 32,
    parameter logic [BYTE_W-1:0] CLR_OP  = 8'h04,
    parameter logic [BYTE_W-1:0] READ_OP = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              rdy_o,
    output logic              irq_drive_o,
    input  logic              pd_i,
    input  logic              voice_busy_i,
    input  logic              cmd_busy_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              rd_valid_i,
    output logic              rd_ready_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // ---- pin synchronizers: {sclk, csn, mosi}
    logic [2:0] pin_lvl, pin_rise, pin_fall;

    spi_sync_edge #(.W(3), .INIT(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, csn_i, mosi_i}),
        .lvl_o   (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    logic sel, sclk_rise, sclk_fall, csn_fall, mosi_lvl;
    logic unused_edges;

    assign sel          = ~pin_lvl[1];
    assign sclk_rise    = pin_rise[2];
    assign sclk_fall    = pin_fall[2];
    assign csn_fall     = pin_fall[1];
    assign mosi_lvl     = pin_lvl[0];
    assign unused_edges = ^{pin_lvl[2], pin_rise[1:0], pin_fall[0]};

    // ---- write buffer
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [BYTE_W-1:0] byte_in;

    spi_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .data_i  (byte_in),
        .pop_i   (fifo_pop),
        .data_o  (rx_data_o),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // ---- protocol state
    front_st_t st_d, st_q;
    status_t   stat;
    logic      in_read, byte_done, fetch, rd_take, clr_hit;

    assign in_read   = (st_q.phase == PH_READ);
    assign rdy_o     = in_read ? ~st_q.rd_wait : ~fifo_full;
    assign byte_in   = {st_q.rx_sh[BYTE_W-2:0], mosi_lvl};
    assign byte_done = sel && sclk_rise && (st_q.bit_cnt == LAST_BIT);

    always_comb begin
        stat = '{pwr_down:   pd_i,
                 ready:      st_q.rdy_flag,
                 irq_pend:   st_q.irq,
                 buf_full:   fifo_full,
                 rsvd:       1'b0,
                 voice_busy: voice_busy_i,
                 buf_avail:  ~fifo_empty,
                 cmd_busy:   cmd_busy_i};
    end

    always_comb begin
        st_d         = st_q;
        st_d.cmd_vld = 1'b0;
        fifo_push    = 1'b0;
        fetch        = 1'b0;
        rd_take      = 1'b0;
        clr_hit      = 1'b0;

        if (!sel) begin
            st_d.phase   = PH_CMD;
            st_d.bit_cnt = '0;
            st_d.rd_wait = 1'b0;
        end else begin
            if (csn_fall && rdy_o) st_d.rdy_flag = 1'b1;

            if (sclk_fall) begin
                if (!rdy_o) begin
                    st_d.rdy_flag = 1'b0;
                    if (in_read) st_d.irq = 1'b1;
                end
                if (st_q.bit_cnt == '0)
                    st_d.tx_sh = in_read ? st_q.rd_hold : stat;
                else
                    st_d.tx_sh = {st_q.tx_sh[BYTE_W-2:0], 1'b0};
            end

            if (sclk_rise) begin
                st_d.rx_sh   = byte_in;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end

            if (byte_done) begin
                case (st_q.phase)
                    PH_CMD: begin
                        st_d.cmd     = byte_in;
                        st_d.cmd_vld = 1'b1;
                        clr_hit      = (byte_in == CLR_OP);
                        if (byte_in == READ_OP) begin
                            st_d.phase = PH_READ;
                            fetch      = 1'b1;
                        end else begin
                            st_d.phase = PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        if (fifo_full) st_d.irq = 1'b1;
                        else           fifo_push = 1'b1;
                    end
                    default: fetch = 1'b1;
                endcase
            end

            if (fetch) begin
                if (rd_valid_i) begin
                    rd_take      = 1'b1;
                    st_d.rd_hold = rd_data_i;
                    st_d.rd_wait = 1'b0;
                end else begin
                    st_d.rd_wait = 1'b1;
                end
            end else if (st_q.rd_wait && rd_valid_i) begin
                rd_take      = 1'b1;
                st_d.rd_hold = rd_data_i;
                st_d.rd_wait = 1'b0;
            end
        end

        if (clr_hit) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_CMD;
            st_q.rdy_flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_pop    = rx_ready_i & ~fifo_empty;
    assign rx_valid_o  = ~fifo_empty;
    assign miso_o      = st_q.tx_sh[BYTE_W-1];
    assign miso_oe_o   = sel;
    assign irq_drive_o = st_q.irq;
    assign cmd_o       = st_q.cmd;
    assign cmd_valid_o = st_q.cmd_vld;
    assign rd_ready_o  = rd_take;

    // R7: interrupt request is sticky until the clear opcode
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_o && !clr_hit |=> irq_drive_o);

    // R9: the clear opcode drops the request on the next edge
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !irq_drive_o);

    // R8: ready flag only comes back at a select edge with the line high
    p_rdy_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy_flag) |-> $past(csn_fall && rdy_o));

    // R2: opcode strobe is a single cycle
    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

endmodule

// File: tb/spi_flow_slave_tb_top.sv
module spi_flow_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int DEPTH      = 32;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b1, csn_i = 1'b1, mosi_i = 1'b0;
    logic       miso_o, miso_oe_o, rdy_o, irq_drive_o;
    logic       pd_i = 1'b0, voice_busy_i = 1'b0, cmd_busy_i = 1'b0;
    logic [7:0] cmd_o, rx_data_o, rd_data_i = 8'h00;
    logic       cmd_valid_o, rx_valid_o, rd_ready_o;
    logic       rx_ready_i = 1'b0, rd_valid_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flow_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rdy_o(rdy_o), .irq_drive_o(irq_drive_o),
        .pd_i(pd_i), .voice_busy_i(voice_busy_i), .cmd_busy_i(cmd_busy_i),
        .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .rx_data_o(rx_data_o),
        .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rd_data_i(rd_data_i),
        .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model
    logic [7:0] mq[$];
    logic       m_irq = 1'b0;
    logic       csn_h1 = 1'b1, csn_h2 = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // per-clock comparison of the output enable against delayed select (R4)
    always @(posedge clk) begin
        csn_h2 <= csn_h1;
        csn_h1 <= csn_i;
    end

    always @(negedge clk) begin
        if (rst_n) chk(miso_oe_o == ~csn_h2, "R4 miso_oe_o", miso_oe_o, ~csn_h2);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic model_push(input logic [7:0] b);
        if (mq.size() < DEPTH) mq.push_back(b);
        else m_irq = 1'b1;
    endtask

    task automatic select();
        @(negedge clk);
        csn_i = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic deselect();
        @(negedge clk);
        csn_i = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input bit pop_edge, output logic [7:0] rx);
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sclk_i = 1'b0;
            mosi_i = tx[i];
            repeat (H) @(negedge clk);
            r[i] = miso_o;
            sclk_i = 1'b1;
            if (i == 0 && pop_edge) begin
                repeat (2) @(negedge clk);
                chk(rx_data_o == mq[0], "R5 head popped at byte boundary", rx_data_o, mq[0]);
                void'(mq.pop_front());
                rx_ready_i = 1'b1;
                @(negedge clk);
                rx_ready_i = 1'b0;
                repeat (H - 3) @(negedge clk);
            end else begin
                repeat (H) @(negedge clk);
            end
        end
        rx = r;
    endtask

    task automatic drain_one(input string req);
        int w = 0;
        @(negedge clk);
        while (!rx_valid_o && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(rx_data_o == mq[0], req, rx_data_o, mq[0]);
        void'(mq.pop_front());
        rx_ready_i = 1'b1;
        @(negedge clk);
        rx_ready_i = 1'b0;
    endtask

    logic [7:0] got;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12: reset state
        chk(rdy_o == 1'b1, "R12 rdy_o", rdy_o, 1);
        chk(irq_drive_o == 1'b0, "R12 irq_drive_o", irq_drive_o, 0);
        chk(miso_oe_o == 1'b0, "R12 miso_oe_o", miso_oe_o, 0);
        chk(rx_valid_o == 1'b0, "R12 rx_valid_o", rx_valid_o, 0);
        chk(cmd_valid_o == 1'b0, "R12 cmd_valid_o", cmd_valid_o, 0);

        // T1: plain write transaction
        pd_i = 1'b1; voice_busy_i = 1'b1; cmd_busy_i = 1'b0;
        select();
        xfer(8'h11, 1'b0, got);
        chk(got == 8'hC4, "R3 status idle", got, 8'hC4);
        chk(cmd_o == 8'h11, "R2 cmd latch", cmd_o, 8'h11);
        xfer(8'hA5, 1'b0, got); model_push(8'hA5);
        xfer(8'h5A, 1'b0, got); model_push(8'h5A);
        xfer(8'h0F, 1'b0, got); model_push(8'h0F);
        deselect();
        for (int k = 0; k < 3; k++) drain_one("R1 write data order");

        // T2: fill, hold while busy, then overrun
        pd_i = 1'b0; voice_busy_i = 1'b0; cmd_busy_i = 1'b1;
        select();
        xfer(8'h20, 1'b0, got);
        for (int k = 0; k < DEPTH; k++) begin
            xfer(8'(8'h40 + k), 1'b0, got);
            model_push(8'(8'h40 + k));
        end
        chk(rdy_o == 1'b0, "R6 busy when full", rdy_o, 0);
        drain_one("R5 head after fill");
        repeat (2) @(negedge clk);
        chk(rdy_o == 1'b1, "R6 ready after pop", rdy_o, 1);
        xfer(8'h80, 1'b0, got); model_push(8'h80);
        chk(irq_drive_o == 1'b0, "R7 no irq when host waited", irq_drive_o, 0);
        xfer(8'h81, 1'b0, got); model_push(8'h81);
        chk(irq_drive_o == m_irq, "R7 overrun irq", irq_drive_o, m_irq);
        deselect();
        chk(rdy_o == 1'b0, "R6 busy while deselected and full", rdy_o, 0);

        select();
        xfer(8'h04, 1'b0, got);
        chk(got == 8'h33, "R8 status after violation", got, 8'h33);
        chk(cmd_o == 8'h04, "R2 cmd latch clear", cmd_o, 8'h04);
        m_irq = 1'b0;
        chk(irq_drive_o == m_irq, "R9 clear opcode", irq_drive_o, m_irq);
        deselect();
        for (int k = 0; k < DEPTH; k++) drain_one("R1 drained order after overrun");
        repeat (2) @(negedge clk);
        chk(rdy_o == 1'b1, "R6 ready when drained", rdy_o, 1);

        // T3: read command
        pd_i = 1'b1; voice_busy_i = 1'b1; cmd_busy_i = 1'b0;
        rd_data_i = 8'h5A; rd_valid_i = 1'b1;
        select();
        xfer(8'hA2, 1'b0, got);
        chk(got == 8'hC4, "R8 ready flag restored", got, 8'hC4);
        rd_valid_i = 1'b0;
        xfer(8'h00, 1'b0, got);
        chk(got == 8'h5A, "R10 read byte", got, 8'h5A);
        chk(rdy_o == 1'b0, "R10 busy with no read data", rdy_o, 0);
        repeat (20) @(negedge clk);
        rd_data_i = 8'h3C; rd_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(rdy_o == 1'b1, "R10 ready once data supplied", rdy_o, 1);
        rd_valid_i = 1'b0;
        xfer(8'h00, 1'b0, got);
        chk(got == 8'h3C, "R10 second read byte", got, 8'h3C);
        xfer(8'h00, 1'b0, got);
        chk(irq_drive_o == 1'b1, "R11 invalid read irq", irq_drive_o, 1);
        deselect();
        select();
        xfer(8'h04, 1'b0, got);
        chk(got == 8'hE4, "R11 irq pending in status", got, 8'hE4);
        chk(irq_drive_o == 1'b0, "R9 clear after read irq", irq_drive_o, 0);
        deselect();

        // T4: byte boundary and consumer pop in the same cycle
        select();
        xfer(8'h30, 1'b0, got);
        for (int k = 1; k <= 4; k++) begin
            xfer(8'(k), 1'b0, got);
            model_push(8'(k));
        end
        xfer(8'h05, 1'b1, got); model_push(8'h05);
        xfer(8'h06, 1'b1, got); model_push(8'h06);
        deselect();
        for (int k = 0; k < 4; k++) drain_one("R5 order after simultaneous push/pop");
        repeat (2) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R5 buffer empty at end", rx_valid_o, 0);
        chk(irq_drive_o == 1'b0, "R7 no irq in T4", irq_drive_o, 0);

        summary();
    end

endmodule